// File: doc/BRIEF.md
# Byte-Serial Stack Processor

This block is a small multicycle processor that keeps no general-purpose registers. Every arithmetic operand and result sits on a private operand stack. Instructions and data share one byte-wide program memory. Instructions are one or three bytes long and packed back to back, so the controller fetches one byte per clock and then runs a short execute sequence chosen by the opcode.

The operand stack is a separate 256-entry byte RAM that grows upward from entry 0. A pointer register marks the current top entry and holds all ones when the stack is empty. The instruction address field is 16 bits wide. The program memory implements the low `PROG_AW` address bits, so upper address bits alias when data is read or written, while a taken branch loads the full 16-bit value into the program counter.

A test port loads bytes into the program memory while the core is held in reset and can read any byte back at any time. The port exposes a halt flag and the current program counter and stack pointer for observation.

Top module: `stackcpu_top`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` is 0, `dbg_sp` is 0xFF (empty stack) and `halted` is 0.
- R2: A write on the test port (`tl_we`) changes program memory only while `rst_n` is low. While the core runs, the write is ignored. `tl_rdata` always shows the byte at `tl_addr`.
- R3: Fetch reads one byte per cycle and adds one to the PC per byte. Opcode 0x02 is one byte long. Opcodes 0x00, 0x01 and 0x04 are followed by a 16-bit address, high byte first.
- R4: Opcode 0x00 (load-to-stack) copies the memory byte at the address onto the stack. The stack pointer rises by one, and the instruction takes 4 cycles in total.
- R5: Opcode 0x01 (store-from-stack) writes the top stack byte to the memory address. The stack pointer falls by one, and the instruction takes 4 cycles in total.
- R6: Opcode 0x02 (sum) replaces the two top bytes with their sum modulo 256. The stack pointer falls by one after the second cycle, and the instruction takes 3 cycles in total.
- R7: Opcode 0x04 (branch-if-equal) pops two bytes; the pointer falls by one on each of its last two cycles. If the two bytes are equal, the PC becomes the address; otherwise it points past the address field. The instruction takes 5 cycles in total.
- R8: Any other opcode raises `halted` one cycle after it is fetched, with the PC one past the opcode. After that, `halted`, PC and SP stay fixed until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables test-port writes |
| tl_we | input | 1 | Test-port write strobe |
| tl_addr | input | PROG_AW | Test-port byte address |
| tl_wdata | input | 8 | Test-port write byte |
| tl_rdata | output | 8 | Program-memory byte at `tl_addr` (combinational) |
| halted | output | 1 | Machine stopped on an unknown opcode |
| dbg_pc | output | 16 | Program counter |
| dbg_sp | output | 8 | Stack pointer |

## Verification
Every register on the way to `dbg_pc`, `dbg_sp` and `halted` updates on the clock edge that ends a cycle. The bench model therefore predicts one triple per clock: fetch cycles advance the PC on each edge, load/store change SP on the 4th edge, sum on the 2nd, and branch on the 4th and 5th with the PC jump on the 5th. `halted` is due on the edge after the bad opcode. The bench drives on the falling edge and compares each prediction on the following falling edge. Memory results appear combinationally on `tl_rdata` and are read once the program has halted.

// File: rtl/stackcpu_pkg.sv
package stackcpu_pkg;

    typedef enum logic [3:0] {
        S_FETCH_OP,
        S_FETCH_ARG,
        S_PUSH_WR,
        S_POP_WR,
        S_SUM_A,
        S_SUM_B,
        S_CMP_A,
        S_CMP_B,
        S_HALT
    } cpu_state_e;

    // Opcode values (decoded by the controller)
    localparam logic [7:0] OPC_LOAD  = 8'h00;
    localparam logic [7:0] OPC_STORE = 8'h01;
    localparam logic [7:0] OPC_SUM   = 8'h02;
    localparam logic [7:0] OPC_JEQ   = 8'h04;

endpackage

// File: rtl/stackcpu_ram.sv
module stackcpu_ram #(
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int NRD = 1
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // One asynchronous read port per requester
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = cells[raddr[g]];
    end
endmodule

// File: rtl/stackcpu_ctrl.sv
module stackcpu_ctrl
    import stackcpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DW     = 8,
    parameter int SP_W   = 8,
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     pm_rdata,
    input  logic [DW-1:0]     stk_rdata,
    output logic [MEM_AW-1:0] pm_addr,
    output logic              pm_we,
    output logic [DW-1:0]     pm_wdata,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_waddr,
    output logic [DW-1:0]     stk_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic [SP_W-1:0]   sp,
    output cpu_state_e        state
);
    localparam int NOPB  = ADDR_W / DW;          // address bytes per operand
    localparam int CNT_W = $clog2(NOPB + 1);
    localparam logic [CNT_W-1:0] LAST_ARG = CNT_W'(NOPB - 1);

    typedef struct packed {
        cpu_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [SP_W-1:0]   sp;
        logic [DW-1:0]     op;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     tmp;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        pm_addr   = r_q.pc[MEM_AW-1:0];
        pm_we     = 1'b0;
        pm_wdata  = '0;
        stk_we    = 1'b0;
        stk_waddr = r_q.sp;
        stk_wdata = '0;

        unique case (r_q.state)
            S_FETCH_OP: begin
                r_d.pc  = r_q.pc + 1'b1;
                r_d.op  = pm_rdata;
                r_d.cnt = '0;
                case (pm_rdata)
                    OPC_SUM:                      r_d.state = S_SUM_A;
                    OPC_LOAD, OPC_STORE, OPC_JEQ: r_d.state = S_FETCH_ARG;
                    default:                      r_d.state = S_HALT;
                endcase
            end
            S_FETCH_ARG: begin
                r_d.pc   = r_q.pc + 1'b1;
                r_d.addr = {r_q.addr[ADDR_W-DW-1:0], pm_rdata};
                if (r_q.cnt == LAST_ARG) begin
                    case (r_q.op)
                        OPC_LOAD:  r_d.state = S_PUSH_WR;
                        OPC_STORE: r_d.state = S_POP_WR;
                        default:   r_d.state = S_CMP_A;
                    endcase
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_PUSH_WR: begin
                pm_addr   = r_q.addr[MEM_AW-1:0];
                stk_we    = 1'b1;
                stk_waddr = r_q.sp + 1'b1;
                stk_wdata = pm_rdata;
                r_d.sp    = r_q.sp + 1'b1;
                r_d.state = S_FETCH_OP;
            end
            S_POP_WR: begin
                pm_addr   = r_q.addr[MEM_AW-1:0];
                pm_we     = 1'b1;
                pm_wdata  = stk_rdata;
                r_d.sp    = r_q.sp - 1'b1;
                r_d.state = S_FETCH_OP;
            end
            S_SUM_A: begin
                r_d.tmp   = stk_rdata;
                r_d.sp    = r_q.sp - 1'b1;
                r_d.state = S_SUM_B;
            end
            S_SUM_B: begin
                stk_we    = 1'b1;
                stk_waddr = r_q.sp;
                stk_wdata = stk_rdata + r_q.tmp;
                r_d.state = S_FETCH_OP;
            end
            S_CMP_A: begin
                r_d.tmp   = stk_rdata;
                r_d.sp    = r_q.sp - 1'b1;
                r_d.state = S_CMP_B;
            end
            S_CMP_B: begin
                r_d.sp    = r_q.sp - 1'b1;
                if (stk_rdata == r_q.tmp) begin
                    r_d.pc = r_q.addr;
                end
                r_d.state = S_FETCH_OP;
            end
            default: begin
                r_d.state = S_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= S_FETCH_OP;
            r_q.pc    <= '0;
            r_q.sp    <= '1;
            r_q.op    <= '0;
            r_q.addr  <= '0;
            r_q.tmp   <= '0;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc    = r_q.pc;
    assign sp    = r_q.sp;
    assign state = r_q.state;
endmodule

// File: rtl/stackcpu_top.sv
module stackcpu_top
    import stackcpu_pkg::*;
#(
    parameter int PROG_AW = 12,
    parameter int ADDR_W  = 16,
    parameter int DW      = 8,
    parameter int SP_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tl_we,
    input  logic [PROG_AW-1:0] tl_addr,
    input  logic [DW-1:0]      tl_wdata,
    output logic [DW-1:0]      tl_rdata,
    output logic               halted,
    output logic [ADDR_W-1:0]  dbg_pc,
    output logic [SP_W-1:0]    dbg_sp
);
    logic [PROG_AW-1:0] core_addr;
    logic               core_we;
    logic [DW-1:0]      core_wdata;
    logic [DW-1:0]      core_rdata;
    logic               pm_we;
    logic [PROG_AW-1:0] pm_waddr;
    logic [DW-1:0]      pm_wdata;
    logic [1:0][DW-1:0] pm_rd;

    logic               stk_we;
    logic [SP_W-1:0]    stk_waddr;
    logic [DW-1:0]      stk_wdata;
    logic [DW-1:0]      stk_rdata;
    logic [SP_W-1:0]    sp;
    cpu_state_e         cur_state;

    // Test port owns the write side only while the core is in reset
    assign pm_we    = rst_n ? core_we    : tl_we;
    assign pm_waddr = rst_n ? core_addr  : tl_addr;
    assign pm_wdata = rst_n ? core_wdata : tl_wdata;
    assign {tl_rdata, core_rdata} = pm_rd;

    stackcpu_ram #(.AW(PROG_AW), .DW(DW), .NRD(2)) u_prog (
        .clk   (clk),
        .we    (pm_we),
        .waddr (pm_waddr),
        .wdata (pm_wdata),
        .raddr ({tl_addr, core_addr}),
        .rdata (pm_rd)
    );

    stackcpu_ram #(.AW(SP_W), .DW(DW), .NRD(1)) u_stack (
        .clk   (clk),
        .we    (stk_we),
        .waddr (stk_waddr),
        .wdata (stk_wdata),
        .raddr (sp),
        .rdata (stk_rdata)
    );

    stackcpu_ctrl #(.ADDR_W(ADDR_W), .DW(DW), .SP_W(SP_W), .MEM_AW(PROG_AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_rdata  (core_rdata),
        .stk_rdata (stk_rdata),
        .pm_addr   (core_addr),
        .pm_we     (core_we),
        .pm_wdata  (core_wdata),
        .stk_we    (stk_we),
        .stk_waddr (stk_waddr),
        .stk_wdata (stk_wdata),
        .pc        (dbg_pc),
        .sp        (sp),
        .state     (cur_state)
    );

    assign dbg_sp = sp;
    assign halted = (cur_state == S_HALT);
endmodule

// File: rtl/stackcpu_chk.sv
module stackcpu_chk
    import stackcpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SP_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halted,
    input logic [ADDR_W-1:0] dbg_pc,
    input logic [SP_W-1:0]   dbg_sp,
    input cpu_state_e        state,
    input logic              pm_we
);
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(dbg_pc) && $stable(dbg_sp))); // R8
    AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH_OP || state == S_FETCH_ARG) |=> (dbg_pc == $past(dbg_pc) + 1'b1)); // R3
    AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_WR) |=> (dbg_sp == $past(dbg_sp) + 1'b1)); // R4
    AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POP_WR) |=> (dbg_sp == $past(dbg_sp) - 1'b1)); // R5
    AST_SUM_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SUM_A) |=> (dbg_sp == $past(dbg_sp) - 1'b1)); // R6
    AST_CMP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMP_B) |=> (dbg_sp == $past(dbg_sp) - 1'b1)); // R7
    AST_RUN_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        pm_we |-> (state == S_POP_WR)); // R2
endmodule

bind stackcpu_top stackcpu_chk #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .halted (halted),
    .dbg_pc (dbg_pc),
    .dbg_sp (dbg_sp),
    .state  (cur_state),
    .pm_we  (pm_we)
);

// File: tb/stackcpu_top_test.sv
module stackcpu_top_test;
    localparam int PAW = 12;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tl_we;
    logic [PAW-1:0] tl_addr;
    logic [7:0]     tl_wdata;
    logic [7:0]     tl_rdata;
    logic           halted;
    logic [15:0]    dbg_pc;
    logic [7:0]     dbg_sp;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    stackcpu_top #(.PROG_AW(PAW)) uut (
        .clk(clk), .rst_n(rst_n), .tl_we(tl_we), .tl_addr(tl_addr),
        .tl_wdata(tl_wdata), .tl_rdata(tl_rdata), .halted(halted),
        .dbg_pc(dbg_pc), .dbg_sp(dbg_sp)
    );

    // Behavioural reference model
    logic [7:0] mm [1 << PAW];
    logic [7:0] ms [256];
    int mpc, msp;
    bit mhalt;
    int    q_pc[$];
    int    q_sp[$];
    bit    q_h[$];
    string q_tag[$];

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_cyc(int pc, int sp, bit h, string tag);
        q_pc.push_back(pc & 16'hFFFF);
        q_sp.push_back(sp & 8'hFF);
        q_h.push_back(h);
        q_tag.push_back(tag);
    endtask

    function automatic int ma(int a);
        return a & ((1 << PAW) - 1);
    endfunction

    task automatic model_step();
        int op, a, npc;
        if (mhalt) begin
            expect_cyc(mpc, msp, 1'b1, "R8");
            return;
        end
        op = mm[ma(mpc)];
        if (op == 2) begin
            expect_cyc(mpc + 1, msp, 1'b0, "R3");
            expect_cyc(mpc + 1, msp - 1, 1'b0, "R6");
            ms[(msp - 1) & 255] = ms[msp & 255] + ms[(msp - 1) & 255];
            msp = (msp - 1) & 255;
            mpc = (mpc + 1) & 16'hFFFF;
            expect_cyc(mpc, msp, 1'b0, "R6");
        end else if (op == 0 || op == 1 || op == 4) begin
            a = {mm[ma(mpc + 1)], mm[ma(mpc + 2)]};
            expect_cyc(mpc + 1, msp, 1'b0, "R3");
            expect_cyc(mpc + 2, msp, 1'b0, "R3");
            expect_cyc(mpc + 3, msp, 1'b0, "R3");
            npc = (mpc + 3) & 16'hFFFF;
            if (op == 0) begin
                msp = (msp + 1) & 255;
                ms[msp] = mm[ma(a)];
                expect_cyc(npc, msp, 1'b0, "R4");
            end else if (op == 1) begin
                mm[ma(a)] = ms[msp];
                msp = (msp - 1) & 255;
                expect_cyc(npc, msp, 1'b0, "R5");
            end else begin
                expect_cyc(npc, msp - 1, 1'b0, "R7");
                if (ms[msp] == ms[(msp - 1) & 255]) npc = a;
                msp = (msp - 2) & 255;
                expect_cyc(npc, msp, 1'b0, "R7");
            end
            mpc = npc;
        end else begin
            mhalt = 1'b1;
            mpc = (mpc + 1) & 16'hFFFF;
            expect_cyc(mpc, msp, 1'b1, "R8");
        end
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) begin
            if (q_pc.size() == 0) model_step();
            @(posedge clk);
            @(negedge clk);
            chk(q_tag[0], "pc", int'(dbg_pc), q_pc[0]);
            chk(q_tag[0], "sp", int'(dbg_sp), q_sp[0]);
            chk(q_h[0] ? "R8" : q_tag[0], "halted", int'(halted), int'(q_h[0]));
            void'(q_pc.pop_front());
            void'(q_sp.pop_front());
            void'(q_h.pop_front());
            void'(q_tag.pop_front());
        end
    endtask

    task automatic load(int a, int d);
        tl_we = 1'b1; tl_addr = PAW'(a); tl_wdata = 8'(d);
        if (!rst_n) mm[ma(a)] = 8'(d);
        @(negedge clk);
        tl_we = 1'b0;
    endtask

    task automatic ld3(int a, int op, int tgt);
        load(a, op);
        load(a + 1, (tgt >> 8) & 255);
        load(a + 2, tgt & 255);
    endtask

    task automatic peek(int a, int exp, string tag);
        tl_addr = PAW'(a);
        #1;
        chk(tag, "mem", int'(tl_rdata), exp);
        chk(tag, "model", int'(mm[ma(a)]), exp);
    endtask

    task automatic model_reset();
        mpc = 0; msp = 255; mhalt = 1'b0;
        q_pc.delete(); q_sp.delete(); q_h.delete(); q_tag.delete();
    endtask

    task automatic check_reset();
        chk("R1", "pc", int'(dbg_pc), 0);
        chk("R1", "sp", int'(dbg_sp), 8'hFF);
        chk("R1", "halted", int'(halted), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tl_we = 1'b0; tl_addr = '0; tl_wdata = '0;
        @(negedge clk);
        check_reset();
        // Data
        load(16'h100, 8'h25);
        load(16'h101, 8'hF0);
        load(16'h102, 8'h07);
        // Program 1
        ld3(0, 0, 16'h0100);
        ld3(3, 0, 16'h0101);
        load(6, 2);               // sum 0x25+0xF0 wraps to 0x15
        ld3(7, 1, 16'h0200);
        ld3(10, 0, 16'h0100);
        ld3(13, 0, 16'h0100);
        ld3(16, 4, 16'h0018);     // equal: taken to 24
        load(19, 8'hFF);          // skipped
        ld3(24, 0, 16'h0101);
        ld3(27, 0, 16'h0100);
        ld3(30, 4, 16'h0013);     // unequal: falls through to 33
        ld3(33, 0, 16'h0102);
        ld3(36, 1, 16'h0201);
        load(39, 8'h03);          // unknown opcode
        check_reset();
        model_reset();
        rst_n = 1'b1;
        run(56);
        chk("R8", "halt pc", int'(dbg_pc), 40);
        peek(16'h200, 8'h15, "R6");
        peek(16'h201, 8'h07, "R5");

        // R2: writes while running are ignored
        load(16'h200, 8'hAA);
        run(2);
        peek(16'h200, 8'h15, "R2");

        // Second run: reset, reload, empty-stack push/pop
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset();
        load(16'h200, 8'h5A);
        peek(16'h200, 8'h5A, "R2");
        ld3(0, 0, 16'h0200);
        ld3(3, 1, 16'h0202);
        load(6, 8'h08);
        model_reset();
        rst_n = 1'b1;
        run(12);
        peek(16'h202, 8'h5A, "R5");
        chk("R4", "empty after pair", int'(dbg_sp), 8'hFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule